// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block gathers interrupt requests from a set of GPIO banks, eight pins to a bank, and combines them into one interrupt line toward the processor. Each pin input is first brought into the clock domain by a two-stage synchronizer. A per-pin trigger code then selects how the synchronized level turns into a pending flag. Level codes make the flag follow the pin. Edge codes latch the flag until software clears it.

Software sees three registers per bank: trigger configuration, mask and pending. It also sees one service register. The service register names the highest-priority active source as a one-based group number plus a pin index, so an interrupt handler needs one read to find the source. Pins are numbered globally bank after bank. Pin `p` of bank `b` is bit `8*b + p` of the pin input vector.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every trigger field holds code 7, every mask bit is 1 and every pending bit is 0. The interrupt output is low and the service register reads 0.
- R2: Registers are decoded from the byte address, word aligned, at a stride of 4 per bank. Trigger configuration sits at 0x00 + 4*b, mask at 0x40 + 4*b, pending at 0x80 + 4*b, and the service register at 0xC0. Configuration and mask read back what was written. Any other address, including banks that are not built, reads 0 and ignores writes.
- R3: For edge codes, writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R4: The edge codes are 2 (falling), 3 (rising) and 4 (both). A pin change applied before clock edge N shows in the pending bit after edge N+2. The bit stays set until it is cleared.
- R5: Under code 0 (level low) or code 1 (level high) the pending bit follows the synchronized pin level with the same latency. A write of 1 to the pending bit has no lasting effect.
- R6: Codes 5, 6 and 7 never set a pending bit.
- R7: A mask bit of 1 keeps its pin out of the interrupt output and out of the service register, while the pending bit is still recorded and readable. A mask bit of 0 lets the pin through.
- R8: The interrupt output is high exactly when some pin is both pending and unmasked.
- R9: The service register is laid out as bits [7:3] = group and bits [2:0] = pin. Group 0 means nothing is active, and group g names bank g-1. Among active pins, the lowest bank wins, and within that bank the lowest pin wins.
- R10: The trigger field of pin p occupies bits [3p+2:3p] of its bank's configuration register, and bits [31:24] read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| pins_i | input | NUM_BANKS*8 | Asynchronous pin levels, bank-major |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with four banks (32 pins) and an 8-bit address. With that setting, the bank-index field can address slots 4 to 15, which have no bank behind them, so the bench can confirm that those slots read as zero and ignore writes. Four banks also put group numbers 1 to 4 and the last pin of the last bank within reach of the service-register priority checks. A vector table sweeps every trigger code against steady, rising, falling and pulsed pins. Directed tests then measure the three-edge latency, pending-clear behaviour, masking, and priority ordering across banks.

// File: rtl/gpio_irq_pkg.sv
// Package: shared constants for the banked GPIO interrupt controller.
// Assumes eight pins per bank, which the service-register layout depends on.
package gpio_irq_pkg;
    localparam int PINS_PER_BANK = 8;
    localparam int PIN_IDX_W     = $clog2(PINS_PER_BANK);
    localparam int TRIG_W        = 3;
    localparam int CFG_BITS      = PINS_PER_BANK * TRIG_W;
    localparam int GRP_W         = 5;
    localparam int SVC_W         = GRP_W + PIN_IDX_W;
    localparam int DATA_W        = 32;
    localparam int MAX_BANKS     = 16;

    // Trigger codes
    localparam logic [TRIG_W-1:0] TRIG_LVL_LO = 3'd0;
    localparam logic [TRIG_W-1:0] TRIG_LVL_HI = 3'd1;
    localparam logic [TRIG_W-1:0] TRIG_FALL   = 3'd2;
    localparam logic [TRIG_W-1:0] TRIG_RISE   = 3'd3;
    localparam logic [TRIG_W-1:0] TRIG_BOTH   = 3'd4;
    localparam logic [TRIG_W-1:0] TRIG_OFF    = 3'd7;

    // Register regions selected by address bits [7:6]
    localparam logic [1:0] RGN_CFG  = 2'd0;
    localparam logic [1:0] RGN_MASK = 2'd1;
    localparam logic [1:0] RGN_PEND = 2'd2;
    localparam logic [1:0] RGN_SVC  = 2'd3;

    function automatic logic trig_is_edge(input logic [TRIG_W-1:0] code);
        return (code == TRIG_FALL) || (code == TRIG_RISE) || (code == TRIG_BOTH);
    endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
// Module: two-flop synchronizer for a vector of independent asynchronous
// pin levels. Assumes each bit is a slow, independent level (no bus coherency).
module gpio_irq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    // Two register stages to resolve metastability
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/gpio_irq_pin_detect.sv
// Module: trigger detection and pending flag for one pin.
// Assumes lvl_i is already synchronized. The clear strobe wins over hold but
// loses to a new edge arriving in the same cycle.
module gpio_irq_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lvl_i,
    input  logic [TRIG_W-1:0] trig_i,
    input  logic              clr_i,
    output logic              pend_o
);
    logic prev_q;
    logic pend_q;
    logic pend_d;
    logic rise;
    logic fall;
    logic held;

    assign rise = lvl_i & ~prev_q;
    assign fall = ~lvl_i & prev_q;
    assign held = pend_q & ~clr_i;

    // Next pending value chosen by the trigger code
    always_comb begin
        case (trig_i)
            TRIG_LVL_LO: pend_d = ~lvl_i;
            TRIG_LVL_HI: pend_d = lvl_i;
            TRIG_FALL:   pend_d = fall | held;
            TRIG_RISE:   pend_d = rise | held;
            TRIG_BOTH:   pend_d = rise | fall | held;
            default:     pend_d = held;
        endcase
    end

    // Previous-level tracker and pending flag
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // R4: an edge-latched flag survives any cycle without a clear
    a_r4_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_is_edge(trig_i) && pend_q && !clr_i) |=> pend_q);

    // R3: clearing a rising-edge flag while the pin is low empties it
    a_r3_clear_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i == TRIG_RISE && clr_i && !lvl_i) |=> !pend_q);

    // R5: level-high mode tracks the synchronized pin one cycle later
    a_r5_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i == TRIG_LVL_HI) |=> (pend_q == $past(lvl_i)));

    // R6: unused codes never raise the flag
    a_r6_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i > TRIG_BOTH && !pend_q) |=> !pend_q);
endmodule

// File: rtl/gpio_irq_bank.sv
// Module: one bank of eight pins: configuration and mask registers, per-pin
// detectors, and the active (pending and unmasked) vector.
// Assumes one-hot write strobes from the top-level decoder.
module gpio_irq_bank
    import gpio_irq_pkg::*;
(
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [PINS_PER_BANK-1:0] lvl_i,
    input  logic                     cfg_we_i,
    input  logic                     mask_we_i,
    input  logic                     pend_we_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [CFG_BITS-1:0]      cfg_o,
    output logic [PINS_PER_BANK-1:0] mask_o,
    output logic [PINS_PER_BANK-1:0] pend_o,
    output logic [PINS_PER_BANK-1:0] act_o
);
    logic [CFG_BITS-1:0]      cfg_q;
    logic [PINS_PER_BANK-1:0] mask_q;
    logic [PINS_PER_BANK-1:0] clr;
    logic [PINS_PER_BANK-1:0] pend;

    // Configuration and mask registers; reset disables and masks every pin
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q  <= '1;
            mask_q <= '1;
        end else begin
            if (cfg_we_i)  cfg_q  <= wdata_i[CFG_BITS-1:0];
            if (mask_we_i) mask_q <= wdata_i[PINS_PER_BANK-1:0];
        end
    end

    // Write-one-to-clear strobes for the pending bits
    assign clr = pend_we_i ? wdata_i[PINS_PER_BANK-1:0] : '0;

    for (genvar p = 0; p < PINS_PER_BANK; p++) begin : g_pin
        gpio_irq_pin_detect u_det (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .lvl_i  (lvl_i[p]),
            .trig_i (cfg_q[p*TRIG_W +: TRIG_W]),
            .clr_i  (clr[p]),
            .pend_o (pend[p])
        );
    end

    assign cfg_o  = cfg_q;
    assign mask_o = mask_q;
    assign pend_o = pend;
    assign act_o  = pend & ~mask_q;

    // R1: state right after reset is release
    a_r1_reset_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> ((&mask_q) && (&cfg_q) && (pend == '0)));

    // R2: a configuration write lands in the next cycle
    a_r2_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> (cfg_q == $past(wdata_i[CFG_BITS-1:0])));
endmodule

// File: rtl/gpio_irq_prio.sv
// Module: fixed-priority encoder that turns the active pin vector into the
// service code {group, pin}. The lowest bank wins, then the lowest pin.
// Assumes NUM_BANKS fits in the group field.
module gpio_irq_prio
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] act_i,
    output logic [SVC_W-1:0]                   svc_o
);
    localparam int NPINS = NUM_BANKS * PINS_PER_BANK;

    logic [GRP_W-1:0]     grp;
    logic [PIN_IDX_W-1:0] pin;

    // Scan from the top down so the lowest index is written last
    always_comb begin
        grp = '0;
        pin = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            for (int p = PINS_PER_BANK - 1; p >= 0; p--) begin
                if (act_i[b*PINS_PER_BANK + p]) begin
                    grp = GRP_W'(b + 1);
                    pin = PIN_IDX_W'(p);
                end
            end
        end
    end

    assign svc_o = {grp, pin};

    // Flat index of the source the service code names, for checking
    int named_idx;
    always_comb begin
        named_idx = 0;
        if (grp != '0) named_idx = (int'(grp) - 1) * PINS_PER_BANK + int'(pin);
    end

    // R9: a nonzero group always names an active pin
    a_r9_svc_names_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grp != '0) |-> (named_idx < NPINS && act_i[named_idx]));

    // R9: group zero only when nothing is active
    a_r9_svc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grp == '0) |-> (act_i == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the banked GPIO interrupt controller. It synchronizes pins,
// decodes the register bus, instantiates the banks and the priority encoder,
// and drives the combined interrupt.
// Assumes single-cycle bus accesses and reads taken combinationally from the address.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pins_i,
    input  logic                               bus_sel_i,
    input  logic                               bus_we_i,
    input  logic [ADDR_W-1:0]                  bus_addr_i,
    input  logic [DATA_W-1:0]                  bus_wdata_i,
    output logic [DATA_W-1:0]                  bus_rdata_o,
    output logic                               irq_o
);
    localparam int NPINS  = NUM_BANKS * PINS_PER_BANK;
    localparam int BIDX_W = $clog2(MAX_BANKS);

    initial assert (NUM_BANKS >= 1 && NUM_BANKS <= MAX_BANKS && ADDR_W >= 8);

    logic [NPINS-1:0]         pins_sync;
    logic [NPINS-1:0]         act;
    logic [SVC_W-1:0]         svc;
    logic [1:0]               region;
    logic [BIDX_W-1:0]        bidx;
    logic                     upper_zero;
    logic                     wr;
    logic [CFG_BITS-1:0]      cfg_a  [NUM_BANKS];
    logic [PINS_PER_BANK-1:0] mask_a [NUM_BANKS];
    logic [PINS_PER_BANK-1:0] pend_a [NUM_BANKS];

    assign region = bus_addr_i[7:6];
    assign bidx   = bus_addr_i[5:2];

    // Address bits above the decoded window must be zero for a hit
    if (ADDR_W > 8) begin : g_upper
        assign upper_zero = ~|bus_addr_i[ADDR_W-1:8];
    end else begin : g_no_upper
        assign upper_zero = 1'b1;
    end

    assign wr = bus_sel_i & bus_we_i & upper_zero;

    gpio_irq_sync #(.WIDTH(NPINS)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pins_i),
        .sync_o  (pins_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = wr && (bidx == BIDX_W'(b));

        gpio_irq_bank u_bank (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .lvl_i     (pins_sync[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .cfg_we_i  (hit && region == RGN_CFG),
            .mask_we_i (hit && region == RGN_MASK),
            .pend_we_i (hit && region == RGN_PEND),
            .wdata_i   (bus_wdata_i),
            .cfg_o     (cfg_a[b]),
            .mask_o    (mask_a[b]),
            .pend_o    (pend_a[b]),
            .act_o     (act[b*PINS_PER_BANK +: PINS_PER_BANK])
        );
    end

    gpio_irq_prio #(.NUM_BANKS(NUM_BANKS)) u_prio (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .act_i  (act),
        .svc_o  (svc)
    );

    // Read multiplexer: region first, then the bank slot
    always_comb begin
        bus_rdata_o = '0;
        if (upper_zero) begin
            if (region == RGN_SVC) begin
                if (bidx == '0) bus_rdata_o = DATA_W'(svc);
            end else begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (bidx == BIDX_W'(b)) begin
                        case (region)
                            RGN_CFG:  bus_rdata_o = DATA_W'(cfg_a[b]);
                            RGN_MASK: bus_rdata_o = DATA_W'(mask_a[b]);
                            default:  bus_rdata_o = DATA_W'(pend_a[b]);
                        endcase
                    end
                end
            end
        end
    end

    // Combined request: any active source
    assign irq_o = |act;

    // R8: the OR path and the priority path agree on activity
    a_r8_irq_matches_svc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (svc[SVC_W-1:PIN_IDX_W] != '0));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
    localparam int NB = 4;
    localparam int NP = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .pins_i (pins),
        .bus_sel_i (sel), .bus_we_i (we), .bus_addr_i (addr),
        .bus_wdata_i (wdata), .bus_rdata_o (rdata), .irq_o (irq)
    );

    // Vector: {bank[10:9], pin[8:6], code[5:3], pattern[2:1], expect[0]}
    // pattern 0 = stay low, 1 = rise and stay, 2 = high pulse, 3 = start high then fall
    localparam logic [10:0] VEC [17] = '{
        {2'd0,3'd0,3'd3,2'd1,1'b1}, {2'd1,3'd4,3'd3,2'd3,1'b0},
        {2'd2,3'd1,3'd2,2'd3,1'b1}, {2'd3,3'd7,3'd2,2'd1,1'b0},
        {2'd0,3'd5,3'd4,2'd1,1'b1}, {2'd1,3'd6,3'd4,2'd3,1'b1},
        {2'd2,3'd2,3'd3,2'd2,1'b1}, {2'd3,3'd0,3'd1,2'd1,1'b1},
        {2'd0,3'd3,3'd1,2'd2,1'b0}, {2'd1,3'd1,3'd1,2'd0,1'b0},
        {2'd2,3'd7,3'd0,2'd0,1'b1}, {2'd3,3'd3,3'd0,2'd1,1'b0},
        {2'd0,3'd6,3'd0,2'd3,1'b1}, {2'd1,3'd0,3'd5,2'd1,1'b0},
        {2'd2,3'd4,3'd6,2'd3,1'b0}, {2'd3,3'd5,3'd7,2'd2,1'b0},
        {2'd3,3'd6,3'd2,2'd2,1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic set_cfg(input int b, input int p, input logic [2:0] code);
        logic [31:0] cur;
        bus_rd(8'(4*b), cur);
        cur = (cur & ~(32'h7 << (3*p))) | (32'(code) << (3*p));
        bus_wr(8'(4*b), cur);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] exp;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        bus_rd(8'h00, d); chk("R1", "cfg0 reset", d, 32'h00FF_FFFF);
        bus_rd(8'h4C, d); chk("R1", "mask3 reset", d, 32'hFF);
        bus_rd(8'h84, d); chk("R1", "pend1 reset", d, 32'h0);
        bus_rd(8'hC0, d); chk("R1", "svc reset", d, 32'h0);
        chk("R1", "irq reset", 32'(irq), 32'h0);

        // Vector table walk: R4 R5 R6 R9
        for (int i = 0; i < 17; i++) begin
            int b, p, g;
            logic [2:0] code;
            logic [1:0] pat;
            logic e;
            b = int'(VEC[i][10:9]); p = int'(VEC[i][8:6]);
            code = VEC[i][5:3]; pat = VEC[i][2:1]; e = VEC[i][0];
            g = b*8 + p;
            pins[g] = (pat == 2'd3);
            wait_cyc(5);
            set_cfg(b, p, code);
            bus_wr(8'(8'h40 + 4*b), 32'hFF & ~(32'h1 << p));
            bus_wr(8'(8'h80 + 4*b), 32'hFF);
            case (pat)
                2'd1: pins[g] = 1'b1;
                2'd2: begin pins[g] = 1'b1; wait_cyc(4); pins[g] = 1'b0; end
                2'd3: pins[g] = 1'b0;
                default: ;
            endcase
            wait_cyc(6);
            bus_rd(8'(8'h80 + 4*b), d);
            chk("R4/R5/R6", $sformatf("vec%0d pend", i), 32'(d[p]), 32'(e));
            chk("R8", $sformatf("vec%0d irq", i), 32'(irq), 32'(e));
            bus_rd(8'hC0, d);
            exp = e ? 32'(((b + 1) << 3) | p) : 32'h0;
            chk("R9", $sformatf("vec%0d svc", i), d, exp);
            bus_wr(8'(8'h40 + 4*b), 32'hFF);
            bus_wr(8'(4*b), 32'h00FF_FFFF);
            pins[g] = 1'b0;
            wait_cyc(5);
            bus_wr(8'(8'h80 + 4*b), 32'hFF);
        end

        // R10 field position and R2 readback
        set_cfg(2, 5, 3'd2);
        bus_rd(8'h08, d);
        chk("R10", "cfg2 field pin5", d, (32'h00FF_FFFF & ~(32'h7 << 15)) | (32'h2 << 15));
        bus_wr(8'h08, 32'hFFFF_FFFF);
        bus_rd(8'h08, d); chk("R10", "cfg upper bits zero", d, 32'h00FF_FFFF);
        bus_wr(8'h44, 32'h5A);
        bus_rd(8'h44, d); chk("R2", "mask1 readback", d, 32'h5A);
        bus_wr(8'h44, 32'hFF);

        // R2 unmapped addresses
        bus_rd(8'hC4, d); chk("R2", "unmapped svc slot", d, 32'h0);
        bus_wr(8'h14, 32'h0);
        bus_rd(8'h14, d); chk("R2", "absent bank5 cfg", d, 32'h0);
        bus_wr(8'h54, 32'h0);
        bus_rd(8'h54, d); chk("R2", "absent bank5 mask", d, 32'h0);
        bus_rd(8'h00, d); chk("R2", "cfg0 untouched", d, 32'h00FF_FFFF);

        // R4 latency: change before edge N visible after edge N+2
        set_cfg(0, 1, 3'd3);
        bus_wr(8'h40, 32'hFD);
        pins[1] = 1'b1;
        wait_cyc(1); bus_rd(8'h80, d); chk("R4", "latency edge1", d, 32'h0);
        wait_cyc(1); bus_rd(8'h80, d); chk("R4", "latency edge2", d, 32'h0);
        wait_cyc(1); bus_rd(8'h80, d); chk("R4", "latency edge3", d, 32'h2);

        // R3 write-one-to-clear
        bus_wr(8'h80, 32'h0);
        bus_rd(8'h80, d); chk("R3", "write 0 keeps", d, 32'h2);
        bus_wr(8'h80, 32'h2);
        bus_rd(8'h80, d); chk("R3", "write 1 clears", d, 32'h0);
        chk("R3", "irq after clear", 32'(irq), 32'h0);
        pins[1] = 1'b0;
        bus_wr(8'h40, 32'hFF);
        bus_wr(8'h00, 32'h00FF_FFFF);

        // R7 masking and R9 priority
        set_cfg(1, 6, 3'd3); set_cfg(1, 3, 3'd3); set_cfg(2, 5, 3'd3);
        pins[14] = 1'b1; pins[11] = 1'b1; pins[21] = 1'b1;
        wait_cyc(5);
        bus_rd(8'h84, d); chk("R7", "masked pend recorded", d, 32'h48);
        chk("R7", "masked irq low", 32'(irq), 32'h0);
        bus_rd(8'hC0, d); chk("R7", "masked svc idle", d, 32'h0);
        bus_wr(8'h44, 32'hB7);
        chk("R7", "unmasked irq", 32'(irq), 32'h1);
        bus_wr(8'h48, 32'hDF);
        bus_rd(8'hC0, d); chk("R9", "lowest bank lowest pin", d, 32'h13);
        bus_wr(8'h84, 32'h08);
        bus_rd(8'hC0, d); chk("R9", "next pin in bank", d, 32'h16);
        bus_wr(8'h84, 32'h40);
        bus_rd(8'hC0, d); chk("R9", "next bank", d, 32'h1D);
        bus_wr(8'h88, 32'h20);
        bus_rd(8'hC0, d); chk("R9", "all cleared svc", d, 32'h0);
        chk("R8", "all cleared irq", 32'(irq), 32'h0);
        pins[14] = 1'b0; pins[11] = 1'b0; pins[21] = 1'b0;
        bus_wr(8'h44, 32'hFF); bus_wr(8'h48, 32'hFF);
        bus_wr(8'h04, 32'h00FF_FFFF); bus_wr(8'h08, 32'h00FF_FFFF);

        // R5 level mode ignores a clear
        set_cfg(3, 2, 3'd1);
        bus_wr(8'h4C, 32'hFB);
        pins[26] = 1'b1;
        wait_cyc(5);
        bus_wr(8'h8C, 32'h04);
        bus_rd(8'h8C, d); chk("R5", "level clear no effect", d, 32'h04);
        bus_rd(8'hC0, d); chk("R9", "last bank svc", d, 32'h22);
        pins[26] = 1'b0;
        wait_cyc(4);
        bus_rd(8'h8C, d); chk("R5", "level released", d, 32'h0);
        chk("R8", "level released irq", 32'(irq), 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule